// File: doc/BRIEF.md
# Dual-Channel Match-Interrupt Timer

This peripheral holds two independent 16-bit counting channels that share a bank of six compare registers. Each channel has a count register, a prescale divider and a five-bit control word. The control word holds a halt flag, a direction flag and a three-bit termination mode. A channel can count toward zero and halt there. It can halt when it reaches one of the shared compare values. It can also free-run and wrap.

Every count step that lands on a compare value latches a pending bit for that compare slot. Software acknowledges a pending bit by writing a one to it. A mask register selects which pending bits raise the single interrupt output.

Software reaches both register windows through a single-cycle bus. A write takes effect at the clock edge where write-enable is high. Read data is combinational from the address. A typical one-shot use is to preload the count, select the halt-on-compare mode with down counting, and wait for the interrupt.

Top module: `dual_match_timer`

## Requirements
- R1: After reset both control words read 0x0010 (halted, down, mode 0). All counts, dividers, compare registers, pending bits and mask bits read 0, and `irq_out` is 0.
- R2: Timer window (`bus_win`=0), byte offsets: channel 0 count 0x00, divider 0x04, control 0x08; channel 1 count 0x0C, divider 0x10, control 0x14; compare register n at 0x18+4n. Interrupt window (`bus_win`=1): pending 0x0, mask 0x4. Control reads back only bits 4:0, and pending and mask only bits 5:0. A write whose address bits 1:0 are not zero changes nothing.
- R3: A running channel (control bit 4 = 0) with divider D steps once every D+1 clocks. The first step comes D+1 clocks after the write that starts it. A halted channel keeps its count.
- R4: Control bit 3 = 1 makes a step add one, and bit 3 = 0 makes it subtract one.
- R5: Mode 0 (bits 2:0 = 0): the step that makes the count 0 also sets bit 4, so the channel halts at 0.
- R6: Modes 1 to 6: the step that makes the count equal to compare register (mode−1) sets bit 4, and the count stays at that value.
- R7: Mode 7 never halts by itself. The count wraps from 0xFFFF to 0x0000 when counting up and from 0x0000 to 0xFFFF when counting down.
- R8: Any step of either channel, in any mode, whose new count equals compare register n sets pending bit n.
- R9: Writing the pending register clears each bit written as one and leaves bits written as zero unchanged.
- R10: `irq_out` is high exactly when some pending bit and its mask bit are both 1.
- R11: If a set event and a write-one-to-clear hit the same pending bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, acts at the rising edge |
| bus_win | input | 1 | Window select: 0 timer registers, 1 interrupt registers |
| bus_addr | input | ADDR_W (6) | Byte address within the window |
| bus_wdata | input | CNT_W (16) | Write data |
| bus_rdata | output | CNT_W (16) | Combinational read data for `bus_win`/`bus_addr` |
| irq_out | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: 16-bit counts, six compare slots, two channels and a 6-bit address. With these values every register offset in the map is real and can be checked by a write followed by a read. With a 16-bit count, the wrap in both directions is reached by preloading a count two steps from the boundary. Dividers of 0 and 2 are enough to show the step spacing of D+1 clocks. One run is timed so that an acknowledge write lands in the same clock as a compare hit, which exercises the rule that the set event wins.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // Control word layout: bit 4 halt, bit 3 up, bits 2:0 mode
    typedef struct packed {
        logic       halt;
        logic       up;
        logic [2:0] mode;
    } tmr_ctrl_t;

    localparam int CTRL_W = $bits(tmr_ctrl_t);

    localparam logic [2:0] MODE_ZERO = 3'd0;
    localparam logic [2:0] MODE_FREE = 3'd7;

    localparam tmr_ctrl_t CTRL_RESET = '{halt: 1'b1, up: 1'b0, mode: MODE_ZERO};

    // Compare slot chosen by a mode value; valid only for modes 1..6
    function automatic int mode_slot(input logic [2:0] m);
        return int'(m) - 1;
    endfunction

endpackage

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int NUM_MATCH = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_cur,
    input  logic                 wr_div,
    input  logic                 wr_ctrl,
    input  logic [CNT_W-1:0]     wdata,
    input  tmr_ctrl_t            ctrl_wdata,
    input  logic [CNT_W-1:0]     match_vals [NUM_MATCH],
    output logic [CNT_W-1:0]     cur,
    output logic [CNT_W-1:0]     div,
    output tmr_ctrl_t            ctrl,
    output logic [NUM_MATCH-1:0] hit
);

    logic [CNT_W-1:0] pre;
    logic [CNT_W-1:0] nxt;
    logic             tick;
    logic             sel_hit;
    logic             stop_now;

    assign tick = !ctrl.halt && (pre == div);
    assign nxt  = ctrl.up ? cur + 1'b1 : cur - 1'b1;

    for (genvar n = 0; n < NUM_MATCH; n++) begin : g_cmp
        assign hit[n] = tick && (nxt == match_vals[n]);
    end

    always_comb begin
        sel_hit = 1'b0;
        for (int n = 0; n < NUM_MATCH; n++) begin
            if (mode_slot(ctrl.mode) == n) sel_hit = hit[n];
        end
        if (ctrl.mode == MODE_ZERO)      stop_now = tick && (nxt == '0);
        else if (ctrl.mode == MODE_FREE) stop_now = 1'b0;
        else                             stop_now = sel_hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur  <= '0;
            div  <= '0;
            pre  <= '0;
            ctrl <= CTRL_RESET;
        end else begin
            if (ctrl.halt || tick) pre <= '0;
            else                   pre <= pre + 1'b1;

            if (wr_cur)    cur <= wdata;
            else if (tick) cur <= nxt;

            if (wr_div) div <= wdata;

            if (wr_ctrl)       ctrl      <= ctrl_wdata;
            else if (stop_now) ctrl.halt <= 1'b1;
        end
    end

    // R3
    hold_when_stopped_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl.halt && !wr_cur) |=> (cur == $past(cur)));

    // R4
    single_step_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_cur |=> ((cur == $past(cur)) || (cur == $past(cur) + 1'b1) ||
                     (cur == $past(cur) - 1'b1)));

    // R7
    free_never_stops_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(ctrl.halt) && !$past(wr_ctrl)) |-> ($past(ctrl.mode) != MODE_FREE));

endmodule

// File: rtl/tmr_irq.sv
module tmr_irq #(
    parameter int NUM_MATCH = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_MATCH-1:0] hit,
    input  logic                 wr_ack,
    input  logic                 wr_mask,
    input  logic [NUM_MATCH-1:0] wdata,
    output logic [NUM_MATCH-1:0] status,
    output logic [NUM_MATCH-1:0] mask,
    output logic                 irq
);

    logic [NUM_MATCH-1:0] clr;

    assign clr = wr_ack ? wdata : '0;
    assign irq = |(status & mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            mask   <= '0;
        end else begin
            status <= (status & ~clr) | hit;
            if (wr_mask) mask <= wdata;
        end
    end

    // R11
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (|hit) |=> ((status & $past(hit)) == $past(hit)));

    // R9
    ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_ack && (hit == '0)) |=> ((status & $past(wdata)) == '0));

    // R10
    irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
        (mask == '0) |-> !irq);

endmodule

// File: rtl/dual_match_timer.sv
module dual_match_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int NUM_MATCH = 6,
    parameter int NUM_CH    = 2,
    parameter int ADDR_W    = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic              bus_win,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              irq_out
);

    localparam int IDX_W      = ADDR_W - 2;
    localparam int REGS_PER   = 3;
    localparam int MATCH_BASE = REGS_PER * NUM_CH;

    logic [IDX_W-1:0]     widx;
    logic                 aligned;
    logic                 tw;
    logic                 iw;
    logic [CNT_W-1:0]     match_q [NUM_MATCH];
    logic [CNT_W-1:0]     ch_cur  [NUM_CH];
    logic [CNT_W-1:0]     ch_div  [NUM_CH];
    tmr_ctrl_t            ch_ctrl [NUM_CH];
    logic [NUM_MATCH-1:0] ch_hit  [NUM_CH];
    logic [NUM_MATCH-1:0] hit_all;
    logic [NUM_MATCH-1:0] status;
    logic [NUM_MATCH-1:0] mask;
    tmr_ctrl_t            ctrl_wdata;

    assign widx       = bus_addr[ADDR_W-1:2];
    assign aligned    = (bus_addr[1:0] == 2'b00);
    assign tw         = bus_we && !bus_win && aligned;
    assign iw         = bus_we &&  bus_win && aligned;
    assign ctrl_wdata = tmr_ctrl_t'(bus_wdata[CTRL_W-1:0]);

    for (genvar n = 0; n < NUM_MATCH; n++) begin : g_match
        always_ff @(posedge clk) begin
            if (rst)                                        match_q[n] <= '0;
            else if (tw && widx == IDX_W'(MATCH_BASE + n))  match_q[n] <= bus_wdata;
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        tmr_channel #(
            .CNT_W     (CNT_W),
            .NUM_MATCH (NUM_MATCH)
        ) u_ch (
            .clk        (clk),
            .rst        (rst),
            .wr_cur     (tw && widx == IDX_W'(REGS_PER * c)),
            .wr_div     (tw && widx == IDX_W'(REGS_PER * c + 1)),
            .wr_ctrl    (tw && widx == IDX_W'(REGS_PER * c + 2)),
            .wdata      (bus_wdata),
            .ctrl_wdata (ctrl_wdata),
            .match_vals (match_q),
            .cur        (ch_cur[c]),
            .div        (ch_div[c]),
            .ctrl       (ch_ctrl[c]),
            .hit        (ch_hit[c])
        );
    end

    always_comb begin
        hit_all = '0;
        for (int c = 0; c < NUM_CH; c++) hit_all = hit_all | ch_hit[c];
    end

    tmr_irq #(
        .NUM_MATCH (NUM_MATCH)
    ) u_irq (
        .clk     (clk),
        .rst     (rst),
        .hit     (hit_all),
        .wr_ack  (iw && widx == IDX_W'(0)),
        .wr_mask (iw && widx == IDX_W'(1)),
        .wdata   (bus_wdata[NUM_MATCH-1:0]),
        .status  (status),
        .mask    (mask),
        .irq     (irq_out)
    );

    always_comb begin
        bus_rdata = '0;
        if (!bus_win) begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (widx == IDX_W'(REGS_PER * c))     bus_rdata = ch_cur[c];
                if (widx == IDX_W'(REGS_PER * c + 1)) bus_rdata = ch_div[c];
                if (widx == IDX_W'(REGS_PER * c + 2)) bus_rdata = CNT_W'(ch_ctrl[c]);
            end
            for (int n = 0; n < NUM_MATCH; n++) begin
                if (widx == IDX_W'(MATCH_BASE + n)) bus_rdata = match_q[n];
            end
        end else begin
            if (widx == IDX_W'(0)) bus_rdata = CNT_W'(status);
            if (widx == IDX_W'(1)) bus_rdata = CNT_W'(mask);
        end
    end

endmodule

// File: tb/dual_match_timer_tb.sv
module dual_match_timer_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic        bus_win = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq_out;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    dual_match_timer u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_win   (bus_win),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    // {window, address, write data, expected read-back}
    localparam logic [38:0] VEC [13] = '{
        {1'b0, 6'h00, 16'h1234, 16'h1234},
        {1'b0, 6'h04, 16'h0005, 16'h0005},
        {1'b0, 6'h08, 16'hFFFF, 16'h001F},
        {1'b0, 6'h0C, 16'hABCD, 16'hABCD},
        {1'b0, 6'h10, 16'h0003, 16'h0003},
        {1'b0, 6'h14, 16'h0018, 16'h0018},
        {1'b0, 6'h18, 16'h1000, 16'h1000},
        {1'b0, 6'h1C, 16'h1001, 16'h1001},
        {1'b0, 6'h20, 16'h0105, 16'h0105},
        {1'b0, 6'h24, 16'h1003, 16'h1003},
        {1'b0, 6'h28, 16'h1004, 16'h1004},
        {1'b0, 6'h2C, 16'h2000, 16'h2000},
        {1'b1, 6'h04, 16'h00FF, 16'h003F}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bw(input logic w, input logic [5:0] a, input logic [15:0] d);
        bus_win = w; bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic w, input logic [5:0] a, output logic [15:0] d);
        bus_win = w; bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [15:0] keep;
        step(3);
        rst = 1'b0;
        step(1);

        // R1 reset state
        rd(0, 6'h00, v); chk("R1 cur0", v, 16'h0000);
        rd(0, 6'h08, v); chk("R1 ctrl0", v, 16'h0010);
        rd(0, 6'h14, v); chk("R1 ctrl1", v, 16'h0010);
        rd(0, 6'h2C, v); chk("R1 match5", v, 16'h0000);
        rd(1, 6'h00, v); chk("R1 pending", v, 16'h0000);
        rd(1, 6'h04, v); chk("R1 mask", v, 16'h0000);
        chk("R1 irq", {15'h0, irq_out}, 16'h0000);

        // R2 register map write/read-back table
        for (int i = 0; i < 13; i++) begin
            bw(VEC[i][38], VEC[i][37:32], VEC[i][31:16]);
            rd(VEC[i][38], VEC[i][37:32], v);
            chk("R2 readback", v, VEC[i][15:0]);
        end
        // R2 misaligned write is ignored
        rd(0, 6'h00, keep);
        bw(0, 6'h03, 16'h7777);
        rd(0, 6'h00, v); chk("R2 misaligned", v, keep);

        bw(1, 6'h04, 16'h0000);
        bw(0, 6'h08, 16'h0010);
        bw(0, 6'h14, 16'h0010);

        // R3 divider 2: steps every 3 clocks
        bw(0, 6'h00, 16'd100);
        bw(0, 6'h04, 16'd2);
        bw(0, 6'h08, 16'h000F);
        step(2); rd(0, 6'h00, v); chk("R3 before first step", v, 16'd100);
        step(1); rd(0, 6'h00, v); chk("R3 first step", v, 16'd101);
        step(3); rd(0, 6'h00, v); chk("R3 second step", v, 16'd102);
        bw(0, 6'h08, 16'h0010);
        step(4); rd(0, 6'h00, v); chk("R3 halted holds", v, 16'd102);

        // R4 down counting, divider 0
        bw(0, 6'h0C, 16'd50);
        bw(0, 6'h10, 16'd0);
        bw(0, 6'h14, 16'h0007);
        step(4); rd(0, 6'h0C, v); chk("R4 down", v, 16'd46);
        bw(0, 6'h14, 16'h0010);
        rd(0, 6'h0C, v); chk("R4 down then halt", v, 16'd45);

        // R7 wrap both ways, no self-halt
        bw(0, 6'h04, 16'd0);
        bw(0, 6'h00, 16'hFFFE);
        bw(0, 6'h08, 16'h000F);
        step(3); rd(0, 6'h00, v); chk("R7 up wrap", v, 16'h0001);
        rd(0, 6'h08, v); chk("R7 still running", v, 16'h000F);
        bw(0, 6'h08, 16'h0010);
        bw(0, 6'h0C, 16'h0001);
        bw(0, 6'h14, 16'h0007);
        step(3); rd(0, 6'h0C, v); chk("R7 down wrap", v, 16'hFFFE);
        bw(0, 6'h14, 16'h0010);

        // R5 mode 0 halts at zero
        bw(0, 6'h00, 16'd3);
        bw(0, 6'h08, 16'h0000);
        step(3); rd(0, 6'h00, v); chk("R5 reaches zero", v, 16'h0000);
        rd(0, 6'h08, v); chk("R5 halt bit", v, 16'h0010);
        step(3); rd(0, 6'h00, v); chk("R5 stays zero", v, 16'h0000);
        rd(1, 6'h00, v); chk("R8 no hit yet", v, 16'h0000);

        // R6 mode 3 halts on compare slot 2 (0x0105)
        bw(0, 6'h0C, 16'h0100);
        bw(0, 6'h14, 16'h000B);
        step(5); rd(0, 6'h0C, v); chk("R6 reach compare", v, 16'h0105);
        rd(0, 6'h14, v); chk("R6 halt bit", v, 16'h001B);
        step(3); rd(0, 6'h0C, v); chk("R6 holds", v, 16'h0105);
        rd(1, 6'h00, v); chk("R8 pending slot2", v, 16'h0004);
        chk("R10 masked off", {15'h0, irq_out}, 16'h0000);

        // R10 mask enables interrupt
        bw(1, 6'h04, 16'h0004);
        chk("R10 irq on", {15'h0, irq_out}, 16'h0001);

        // R9 write-one-to-clear
        bw(1, 6'h00, 16'h0000);
        rd(1, 6'h00, v); chk("R9 zero write", v, 16'h0004);
        bw(1, 6'h00, 16'h003B);
        rd(1, 6'h00, v); chk("R9 other bits", v, 16'h0004);
        bw(1, 6'h00, 16'h0004);
        rd(1, 6'h00, v); chk("R9 cleared", v, 16'h0000);
        chk("R10 irq off", {15'h0, irq_out}, 16'h0000);

        // R8 free-run hit on slot 5, no halt
        bw(0, 6'h00, 16'h1FFE);
        bw(0, 6'h08, 16'h000F);
        step(2);
        rd(1, 6'h00, v); chk("R8 pending slot5", v, 16'h0020);
        step(2); rd(0, 6'h00, v); chk("R8 keeps running", v, 16'h2002);
        bw(0, 6'h08, 16'h0010);

        // R11 set and clear in the same cycle
        bw(0, 6'h00, 16'h1FFE);
        bw(0, 6'h08, 16'h000F);
        step(1);
        bw(1, 6'h00, 16'h0020);
        rd(1, 6'h00, v); chk("R11 set wins", v, 16'h0020);
        bw(0, 6'h08, 16'h0010);
        bw(1, 6'h00, 16'h0020);
        rd(1, 6'h00, v); chk("R9 final clear", v, 16'h0000);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule